// File: doc/BRIEF.md
# Omega Multistage Switching Fabric

This block is a pipelined Omega fabric that connects `N_PORTS` inputs to `N_PORTS` outputs, where `N_PORTS` is a power of two. Every cycle, each input may offer one transfer. A transfer consists of a valid flag, a source index, a destination index and a data word. The fabric has log2(`N_PORTS`) columns. Each column first rewires the lines by rotating every line number one bit to the left, and then passes them through `N_PORTS/2` two-by-two switching elements. Each element is set either straight or crossed. The setting depends on whether the source bit and the destination bit for that column agree.

The fabric is blocking: two transfers can ask one element for opposite settings. When that happens, the transfer on the element's upper input is served. The other transfer is dropped and reported through a per-input blocked flag. There is one register per column, so a full set of results appears log2(`N_PORTS`) cycles after the inputs. A fresh set can be offered every cycle.

Top module: `omega_net`

## Requirements
- R1: The fabric has log2(`N_PORTS`) columns of `N_PORTS/2` elements, with one register per column. The results for a set of inputs appear exactly log2(`N_PORTS`) clock edges after that set is sampled. `N_PORTS` must be a power of two of at least 2.
- R2: A transfer that is not blocked leaves on the output port whose number equals its destination index, and it carries its own data word.
- R3: Column k (counting from 1) compares bit k, counted from the most significant bit, of the source index with the same bit of the destination index. If the bits are equal the element is straight; if they differ it is crossed. The source index must equal the number of the input port. A transfer that is alone in the fabric always reaches its destination.
- R4: Before each column, line i moves to the line numbered by rotating i left by one bit. Within an element, the even-numbered line is the upper input. If both inputs are valid and need different settings, the upper input's setting is used.
- R5: The losing transfer raises `out_blocked` at the bit of the input port it came from. This happens with the same latency as the outputs. Its data appears on no output.
- R6: An output port that carries no transfer shows `out_valid` at 0 and `out_data` all zero.
- R7: A new set of inputs is accepted on every clock edge. Consecutive sets do not affect each other's results.
- R8: While `rst_n` is low (an asynchronous, active-low reset), every output is 0.
- R9: An input whose valid flag is 0 is never flagged blocked, never produces an output, and the values on its other fields have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | N_PORTS | Per-input transfer request |
| in_src | input | N_PORTS*log2(N_PORTS) | Source index per input, input i in slice i |
| in_dst | input | N_PORTS*log2(N_PORTS) | Destination index per input |
| in_data | input | N_PORTS*DATA_W | Data word per input |
| out_valid | output | N_PORTS | Transfer present on each output port |
| out_data | output | N_PORTS*DATA_W | Data word on each output port |
| out_blocked | output | N_PORTS | Per-input flag: the transfer was refused |

## Verification
The bench builds the fabric with eight ports and 8-bit data. With these values there are three columns, which is enough to reach both the first-column conflict 010→111 against 110→100 and conflicts that only arise in later columns after earlier crossings. Every source-to-destination pair is sent alone to confirm the bit-comparison routing. Whole permutations and random back-to-back sets then exercise the upper-wins rule and pipeline independence. An independent line-tracking model supplies the expected outputs.

// File: rtl/omega_pkg.sv
package omega_pkg;

   typedef enum logic {
      SW_STRAIGHT = 1'b0,
      SW_CROSSED  = 1'b1
   } sw_mode_e;

   // line number after the shuffle wiring: rotate left by one bit
   function automatic int unsigned shuffle_line(input int unsigned line, input int unsigned width);
      int unsigned mask;
      mask = (32'd1 << width) - 1;
      return ((line << 1) | (line >> (width - 1))) & mask;
   endfunction

endpackage

// File: rtl/omega_switch2.sv
module omega_switch2
   import omega_pkg::*;
#(
   parameter int LANE_W  = 18,
   parameter int VLD_POS = 17,
   parameter int SRC_LO  = 11,
   parameter int DST_LO  = 8,
   parameter int BIT     = 2
) (
   input  logic [LANE_W-1:0] up_i,
   input  logic [LANE_W-1:0] lo_i,
   output logic [LANE_W-1:0] up_o,
   output logic [LANE_W-1:0] lo_o,
   output logic              lo_blk_o
);

   logic              up_v;
   logic              lo_v;
   logic              up_need;
   logic              lo_need;
   sw_mode_e          mode;
   logic [LANE_W-1:0] lo_eff;

   always_comb begin
      up_v     = up_i[VLD_POS];
      lo_v     = lo_i[VLD_POS];
      up_need  = up_i[SRC_LO+BIT] ^ up_i[DST_LO+BIT];
      lo_need  = lo_i[SRC_LO+BIT] ^ lo_i[DST_LO+BIT];
      lo_blk_o = up_v & lo_v & (up_need ^ lo_need);
      if (up_v)      mode = sw_mode_e'(up_need);
      else if (lo_v) mode = sw_mode_e'(lo_need);
      else           mode = SW_STRAIGHT;
      lo_eff = lo_blk_o ? '0 : lo_i;
      if (mode == SW_CROSSED) begin
         up_o = lo_eff;
         lo_o = up_i;
      end else begin
         up_o = up_i;
         lo_o = lo_eff;
      end
   end

endmodule

// File: rtl/omega_stage.sv
module omega_stage
   import omega_pkg::*;
#(
   parameter int N_PORTS = 8,
   parameter int IDX_W   = 3,
   parameter int DATA_W  = 8,
   parameter int STAGE   = 0
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic [N_PORTS*(DATA_W+3*IDX_W+1)-1:0] lane_i,
   input  logic [N_PORTS-1:0]                blk_i,
   output logic [N_PORTS*(DATA_W+3*IDX_W+1)-1:0] lane_o,
   output logic [N_PORTS-1:0]                blk_o
);

   localparam int DST_LO  = DATA_W;
   localparam int SRC_LO  = DATA_W + IDX_W;
   localparam int ORG_LO  = DATA_W + 2*IDX_W;
   localparam int VLD_POS = DATA_W + 3*IDX_W;
   localparam int LW      = VLD_POS + 1;
   localparam int N_SW    = N_PORTS / 2;
   localparam int BIT     = IDX_W - 1 - STAGE;

   logic [N_PORTS*LW-1:0] shuf;
   logic [N_PORTS*LW-1:0] sw_out;
   logic [N_SW-1:0]       lo_blk;
   logic [IDX_W-1:0]      lo_org [N_SW];
   logic [N_PORTS-1:0]    blk_nxt;
   logic [N_PORTS-1:0]    vld_in;
   logic [N_PORTS-1:0]    vld_sw;

   for (genvar i = 0; i < N_PORTS; i++) begin : g_wire
      localparam int unsigned J = shuffle_line(i, IDX_W);
      assign shuf[J*LW +: LW] = lane_i[i*LW +: LW];
      assign vld_in[i] = lane_i[i*LW + VLD_POS];
      assign vld_sw[i] = sw_out[i*LW + VLD_POS];
   end

   for (genvar s = 0; s < N_SW; s++) begin : g_sw
      omega_switch2 #(
         .LANE_W (LW),
         .VLD_POS(VLD_POS),
         .SRC_LO (SRC_LO),
         .DST_LO (DST_LO),
         .BIT    (BIT)
      ) u_sw (
         .up_i    (shuf[(2*s)*LW +: LW]),
         .lo_i    (shuf[(2*s+1)*LW +: LW]),
         .up_o    (sw_out[(2*s)*LW +: LW]),
         .lo_o    (sw_out[(2*s+1)*LW +: LW]),
         .lo_blk_o(lo_blk[s])
      );
      assign lo_org[s] = shuf[(2*s+1)*LW + ORG_LO +: IDX_W];
   end

   always_comb begin
      blk_nxt = blk_i;
      for (int s = 0; s < N_SW; s++) begin
         if (lo_blk[s]) blk_nxt[lo_org[s]] = 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         lane_o <= '0;
         blk_o  <= '0;
      end else begin
         lane_o <= sw_out;
         blk_o  <= blk_nxt;
      end
   end

   // R4: every valid transfer entering the column is either forwarded or refused
   a_r4_conserve: assert property (@(posedge clk) disable iff (!rst_n)
      $countones(vld_in) == $countones(vld_sw) + $countones(lo_blk));

   // R5: a blocked flag raised in an earlier column is carried forward
   a_r5_blk_kept: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(blk_i) & ~blk_o) == '0);

endmodule

// File: rtl/omega_net.sv
module omega_net
   import omega_pkg::*;
#(
   parameter int N_PORTS = 8,
   parameter int DATA_W  = 8
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [N_PORTS-1:0]                  in_valid,
   input  logic [N_PORTS*$clog2(N_PORTS)-1:0]  in_src,
   input  logic [N_PORTS*$clog2(N_PORTS)-1:0]  in_dst,
   input  logic [N_PORTS*DATA_W-1:0]           in_data,
   output logic [N_PORTS-1:0]                  out_valid,
   output logic [N_PORTS*DATA_W-1:0]           out_data,
   output logic [N_PORTS-1:0]                  out_blocked
);

   localparam int IDX_W   = $clog2(N_PORTS);
   localparam int N_STG   = IDX_W;
   localparam int DST_LO  = DATA_W;
   localparam int ORG_LO  = DATA_W + 2*IDX_W;
   localparam int VLD_POS = DATA_W + 3*IDX_W;
   localparam int LW      = VLD_POS + 1;

   if (N_PORTS < 2 || (N_PORTS & (N_PORTS - 1)) != 0) begin : g_bad_ports
      $error("omega_net: N_PORTS must be a power of two, at least 2");
   end
   if (DATA_W < 1) begin : g_bad_data
      $error("omega_net: DATA_W must be at least 1");
   end

   logic [N_PORTS*LW-1:0] lane_c [N_STG+1];
   logic [N_PORTS-1:0]    blk_c  [N_STG+1];

   for (genvar i = 0; i < N_PORTS; i++) begin : g_in
      localparam logic [IDX_W-1:0] ORG = IDX_W'(i);
      assign lane_c[0][i*LW +: LW] = in_valid[i]
         ? {1'b1, ORG, in_src[i*IDX_W +: IDX_W], in_dst[i*IDX_W +: IDX_W], in_data[i*DATA_W +: DATA_W]}
         : '0;
   end
   assign blk_c[0] = '0;

   for (genvar k = 0; k < N_STG; k++) begin : g_stg
      omega_stage #(
         .N_PORTS(N_PORTS),
         .IDX_W  (IDX_W),
         .DATA_W (DATA_W),
         .STAGE  (k)
      ) u_stage (
         .clk   (clk),
         .rst_n (rst_n),
         .lane_i(lane_c[k]),
         .blk_i (blk_c[k]),
         .lane_o(lane_c[k+1]),
         .blk_o (blk_c[k+1])
      );
   end

   for (genvar j = 0; j < N_PORTS; j++) begin : g_out
      assign out_valid[j] = lane_c[N_STG][j*LW + VLD_POS];
      assign out_data[j*DATA_W +: DATA_W] = out_valid[j] ? lane_c[N_STG][j*LW +: DATA_W] : '0;

      // R2: a delivered transfer sits on the port named by its destination
      a_r2_dest_match: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[j] |-> (lane_c[N_STG][j*LW + DST_LO +: IDX_W] == IDX_W'(j)));

      // R5: a delivered transfer is never also reported as refused
      a_r5_winner_free: assert property (@(posedge clk) disable iff (!rst_n)
         out_valid[j] |-> !out_blocked[lane_c[N_STG][j*LW + ORG_LO +: IDX_W]]);
   end

   assign out_blocked = blk_c[N_STG];

endmodule

// File: tb/omega_net_tb_top.sv
module omega_net_tb_top;

   localparam int N       = 8;
   localparam int DW      = 8;
   localparam int IW      = 3;
   localparam int S       = 3;
   localparam int CLK_PER = 10;
   localparam int WD_MAX  = 20000;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [N-1:0]      in_valid = '0;
   logic [N*IW-1:0]   in_src = '0;
   logic [N*IW-1:0]   in_dst = '0;
   logic [N*DW-1:0]   in_data = '0;
   logic [N-1:0]      out_valid;
   logic [N*DW-1:0]   out_data;
   logic [N-1:0]      out_blocked;

   always #(CLK_PER/2) clk = ~clk;

   omega_net #(.N_PORTS(N), .DATA_W(DW)) dut_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .in_valid   (in_valid),
      .in_src     (in_src),
      .in_dst     (in_dst),
      .in_data    (in_data),
      .out_valid  (out_valid),
      .out_data   (out_data),
      .out_blocked(out_blocked)
   );

   typedef struct {
      int          due;
      logic [N-1:0]    v;
      logic [N*DW-1:0] d;
      logic [N-1:0]    b;
      string           tag;
   } exp_t;

   exp_t q[$];
   int   n_checks = 0;
   int   n_errors = 0;
   int   edges = 0;
   int   wd = 0;

   logic          sv   [N];
   logic [IW-1:0] sd   [N];
   logic [DW-1:0] sdat [N];

   always @(posedge clk) begin
      if (rst_n) edges <= edges + 1;
      wd <= wd + 1;
      if (wd > WD_MAX) begin
         n_errors = n_errors + 1;
         $display("FAIL watchdog expired act=%0d exp<=%0d", wd, WD_MAX);
         $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
         $finish;
      end
   end

   function automatic int rot(input int x);
      return ((x << 1) | (x >> (IW - 1))) & (N - 1);
   endfunction

   task automatic chk(input string tag, input string what, input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s %s act=%h exp=%h", tag, what, act, exp);
      end
   endtask

   // monitor: compare results as they fall due
   always @(negedge clk) begin
      if (rst_n) begin
         while (q.size() > 0 && q[0].due == edges) begin
            chk(q[0].tag, "out_valid",   {{(N*DW-N){1'b0}}, out_valid},   {{(N*DW-N){1'b0}}, q[0].v});
            chk(q[0].tag, "out_data",    out_data,                        q[0].d);
            chk(q[0].tag, "out_blocked", {{(N*DW-N){1'b0}}, out_blocked}, {{(N*DW-N){1'b0}}, q[0].b});
            void'(q.pop_front());
         end
      end
   end

   // driver: present one set (source index = port) and predict its result
   task automatic drive_set(input string tag);
      int   line [N];
      bit   alive [N];
      exp_t e;
      e.v = '0; e.d = '0; e.b = '0; e.tag = tag;
      e.due = edges + S;
      for (int m = 0; m < N; m++) begin
         in_valid[m]            = sv[m];
         in_src[m*IW +: IW]     = IW'(m);
         in_dst[m*IW +: IW]     = sd[m];
         in_data[m*DW +: DW]    = sdat[m];
         line[m]  = m;
         alive[m] = sv[m];
      end
      for (int k = 0; k < S; k++) begin
         int b;
         int occ [N];
         b = IW - 1 - k;
         for (int m = 0; m < N; m++) occ[m] = -1;
         for (int m = 0; m < N; m++) if (alive[m]) begin
            line[m] = rot(line[m]);
            occ[line[m]] = m;
         end
         for (int w = 0; w < N/2; w++) begin
            int u, l;
            u = occ[2*w];
            l = occ[2*w+1];
            if (u >= 0 && l >= 0 && ((m_bit(u, b) ^ sd[u][b]) != (m_bit(l, b) ^ sd[l][b]))) begin
               alive[l] = 1'b0;
               e.b[l]   = 1'b1;
            end
         end
         for (int m = 0; m < N; m++) if (alive[m]) line[m] = line[m] ^ int'(m_bit(m, b) ^ sd[m][b]);
      end
      for (int m = 0; m < N; m++) if (alive[m]) begin
         e.v[line[m]] = 1'b1;
         e.d[line[m]*DW +: DW] = sdat[m];
      end
      q.push_back(e);
      @(negedge clk);
   endtask

   function automatic logic m_bit(input int m, input int b);
      logic [IW-1:0] s;
      s = IW'(m);
      return s[b];
   endfunction

   task automatic clear_set();
      for (int m = 0; m < N; m++) begin
         sv[m] = 1'b0; sd[m] = '0; sdat[m] = '0;
      end
   endtask

   initial begin
      clear_set();
      repeat (3) @(negedge clk);
      // R8: outputs held at zero while reset is low
      chk("R8", "reset outputs", {{(N*DW-2*N){1'b0}}, out_valid, out_blocked} | out_data, '0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R8", "after reset", {{(N*DW-2*N){1'b0}}, out_valid, out_blocked} | out_data, '0);

      // R1: identity permutation, checked exactly S edges later
      for (int m = 0; m < N; m++) begin sv[m] = 1'b1; sd[m] = IW'(m); sdat[m] = DW'(8'h10 + m); end
      drive_set("R1");
      clear_set();
      drive_set("R6");

      // R3: each source to each destination alone
      for (int i = 0; i < N; i++) begin
         for (int j = 0; j < N; j++) begin
            clear_set();
            sv[i] = 1'b1; sd[i] = IW'(j); sdat[i] = DW'(i * 16 + j + 1);
            drive_set("R3");
         end
      end

      // R4: 010->111 against 110->100, upper input (port 2) wins; R5 for port 6
      clear_set();
      sv[2] = 1'b1; sd[2] = 3'b111; sdat[2] = 8'hA2;
      sv[6] = 1'b1; sd[6] = 3'b100; sdat[6] = 8'hB6;
      drive_set("R4");
      clear_set();
      sv[2] = 1'b1; sd[2] = 3'b111; sdat[2] = 8'h5A;
      sv[6] = 1'b1; sd[6] = 3'b100; sdat[6] = 8'h6B;
      sv[0] = 1'b1; sd[0] = 3'b111; sdat[0] = 8'h01;
      drive_set("R5");

      // R2: whole permutations
      clear_set();
      for (int m = 0; m < N; m++) begin sv[m] = 1'b1; sd[m] = IW'(N - 1 - m); sdat[m] = DW'(8'h80 + m); end
      drive_set("R2");
      for (int m = 0; m < N; m++) begin sd[m] = IW'((m + 1) % N); sdat[m] = DW'(8'hC0 + m); end
      drive_set("R2");
      for (int m = 0; m < N; m++) begin sd[m] = IW'(m ^ 3); sdat[m] = DW'(8'h40 + m); end
      drive_set("R2");

      // R9: invalid inputs carry noise on every other field
      for (int m = 0; m < N; m++) begin sv[m] = 1'b0; sd[m] = IW'($urandom); sdat[m] = DW'($urandom | 1); end
      drive_set("R9");
      sv[5] = 1'b1; sd[5] = 3'b000; sdat[5] = 8'h55;
      drive_set("R9");

      // R7: random sets on consecutive edges
      for (int t = 0; t < 60; t++) begin
         for (int m = 0; m < N; m++) begin
            sv[m] = 1'($urandom); sd[m] = IW'($urandom); sdat[m] = DW'($urandom);
         end
         drive_set("R7");
      end

      clear_set();
      for (int t = 0; t < S + 2; t++) drive_set("R6");
      repeat (S + 2) @(negedge clk);
      if (q.size() != 0) begin
         n_errors++;
         $display("FAIL R1 pending results act=%0d exp=0", q.size());
      end
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
   end

endmodule